// File: doc/BRIEF.md
# DDR SDRAM Command Sequencer

This block stands between a simple host request port and a four-bank double-data-rate SDRAM. It takes one read or write request at a time, each naming a bank, a row, a starting column and an optional auto-precharge. For each request it issues the commands the memory needs. If the bank has no open row, it opens the row. If a different row is open, it first closes that row and then opens the new one. Finally it issues the column command. Exactly one command, possibly NOP, leaves the block on every rising clock edge.

The block keeps a small timer and an open-row record for each bank. It enforces the row-open-to-column delay and the precharge period. For reads it also produces the data-valid window from the programmed CAS latency, including the 2.5-cycle setting. That setting is shown as a half-cycle flag on a window that opens two full cycles after the read. An interval counter schedules auto refresh. A pending refresh stops new requests from being accepted. It closes every open bank with one precharge-all command and then issues the refresh. The block moves no data; it only marks when read or write data belongs on the bus.

Top module: `ddr_cmd_seq`

## Requirements
- R1: While reset is high, the command output is NOP and both data windows are low. After reset, req_ready is high.
- R2: A request to a bank with no open row issues ACT, with the bank on cmd_bank and the row on cmd_addr. Exactly 3 cycles later it issues RD or WR, with the column on cmd_addr. Every accepted request ends in exactly one column command carrying its bank, column, direction and auto-precharge flag.
- R3: A request whose row is already open in its bank issues the column command without any ACT.
- R4: A request to a bank holding a different open row issues PRE to that bank. ACT follows exactly 3 cycles later, and the column command follows 3 cycles after the ACT.
- R5: A column command with cmd_ap high closes its bank with no PRE command. The next ACT to that bank comes no sooner than L + B + 3 cycles after the column command. L is the data latency (CAS cycles for reads, 1 for writes) and B is the burst length divided by 2.
- R6: The burst code cfg_bl selects 2 (code 0), 4 (code 1) or 8 (codes 2 and 3) beats. After RD, rd_valid is high for B consecutive cycles. It starts 2 cycles after RD when cfg_cl is 0 or 1, and 3 cycles after RD when cfg_cl is 2 or 3.
- R7: With cfg_cl = 1 (CAS 2.5), rd_half is high in every cycle of the read window and in no other cycle. With any other CAS code it stays low.
- R8: After WR, wr_valid is high for B consecutive cycles, starting 1 cycle after the WR.
- R9: A column command is not issued before the previous data window has ended. PRE, PREA and REF never coincide with an open data window.
- R10: Refresh becomes pending every REF_INT cycles. While it is pending, no new request is accepted. If any bank is open, PREA comes first, and REF follows no sooner than 3 cycles later. After REF, no ACT is issued for 8 cycles. The interval between REF commands never exceeds REF_INT plus 40 cycles.
- R11: The command codes are NOP=0, ACT=1, RD=2, WR=3, PRE=4, PREA=5 and REF=6. No other code appears, and NOP is issued on every cycle with no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands leave on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge if req_valid is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Starting column |
| req_ap | input | 1 | Close the row after the burst |
| cfg_bl | input | 2 | Burst length code |
| cfg_cl | input | 2 | CAS latency code |
| cmd_o | output | 3 | Command code |
| cmd_bank | output | 2 | Bank of the command |
| cmd_addr | output | max(ROW_W,COL_W) | Row for ACT, column for RD/WR |
| cmd_ap | output | 1 | Auto-precharge flag of a column command |
| rd_valid | output | 1 | Read data window |
| rd_half | output | 1 | Read data shifted by half a cycle |
| wr_valid | output | 1 | Write data window |

## Verification
A refresh interval can expire while a request is partway through its row work. It can also expire while its data window is still open. The random phase holds requests back to back and drives rows from a set of three. This keeps banks open and windows busy whenever the refresh counter fires. A per-bank scoreboard judges each command on the cycle it appears. PREA and REF must wait for the window to close and for every bank timer to expire. The interrupted request must still complete with the bank, column and flags it was accepted with.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PREA = 3'd5,
    CMD_REF  = 3'd6
  } ddr_cmd_e;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_WORK = 1'b1
  } seq_state_e;

  // clock cycles occupied by one burst (beats / 2)
  function automatic logic [3:0] burst_clocks(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd1;
      2'd1:    return 4'd2;
      default: return 4'd4;
    endcase
  endfunction

  // whole cycles from RD to first data cycle
  function automatic logic [1:0] cas_whole(input logic [1:0] code);
    case (code)
      2'd0, 2'd1: return 2'd2;
      default:    return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/ddr_bank_trk.sv
module ddr_bank_trk #(
  parameter int ROW_W = 13,
  parameter int TMR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_open,
  input  logic [ROW_W-1:0] set_row,
  input  logic             clr_open,
  input  logic             ld_en,
  input  logic [TMR_W-1:0] ld_val,
  output logic             is_open,
  output logic [ROW_W-1:0] row_q,
  output logic             tmr_zero
);

  logic [TMR_W-1:0] tmr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      is_open <= 1'b0;
      row_q   <= '0;
      tmr_q   <= '0;
    end else begin
      if (set_open) begin
        is_open <= 1'b1;
        row_q   <= set_row;
      end else if (clr_open) begin
        is_open <= 1'b0;
      end
      if (ld_en)
        tmr_q <= ld_val;
      else if (tmr_q != '0)
        tmr_q <= tmr_q - 1'b1;
    end
  end

  assign tmr_zero = (tmr_q == '0);

endmodule

// File: rtl/ddr_data_win.sv
module ddr_data_win #(
  parameter int AGE_W = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fire,
  input  logic       fire_wr,
  input  logic [1:0] lat_i,
  input  logic [3:0] clocks_i,
  input  logic       half_i,
  output logic       col_ok,
  output logic       rd_valid,
  output logic       rd_half,
  output logic       wr_valid
);

  logic             act_q, wr_q, half_q;
  logic [AGE_W-1:0] age_q, start_q, stop_q;
  logic             act_n, wr_n, half_n, in_n;
  logic [AGE_W-1:0] age_n, start_n, stop_n;

  always_comb begin
    act_n   = act_q;
    wr_n    = wr_q;
    half_n  = half_q;
    age_n   = age_q;
    start_n = start_q;
    stop_n  = stop_q;
    if (fire) begin
      act_n   = 1'b1;
      wr_n    = fire_wr;
      half_n  = half_i & ~fire_wr;
      age_n   = '0;
      start_n = fire_wr ? AGE_W'(1) : AGE_W'(lat_i);
      stop_n  = start_n + AGE_W'(clocks_i);
    end else if (act_q) begin
      age_n = age_q + AGE_W'(1);
      if (age_n >= stop_q)
        act_n = 1'b0;
    end
    in_n = act_n && (age_n >= start_n) && (age_n < stop_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= 1'b0;
      wr_q     <= 1'b0;
      half_q   <= 1'b0;
      age_q    <= '0;
      start_q  <= '0;
      stop_q   <= '0;
      rd_valid <= 1'b0;
      rd_half  <= 1'b0;
      wr_valid <= 1'b0;
    end else begin
      act_q    <= act_n;
      wr_q     <= wr_n;
      half_q   <= half_n;
      age_q    <= age_n;
      start_q  <= start_n;
      stop_q   <= stop_n;
      rd_valid <= in_n & ~wr_n;
      rd_half  <= in_n & ~wr_n & half_n;
      wr_valid <= in_n & wr_n;
    end
  end

  // a new column command may leave on the coming edge
  assign col_ok = !act_q || ((age_q + AGE_W'(1)) >= stop_q);

endmodule

// File: rtl/ddr_ref_timer.sv
module ddr_ref_timer #(
  parameter int REF_INT = 780
) (
  input  logic clk,
  input  logic rst,
  input  logic ack,
  output logic pend
);

  localparam int CNT_W = $clog2(REF_INT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      pend  <= 1'b0;
    end else begin
      if (cnt_q == CNT_W'(REF_INT - 1)) begin
        cnt_q <= '0;
        pend  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (ack)
          pend <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ddr_cmd_seq.sv
module ddr_cmd_seq
  import ddr_seq_pkg::*;
#(
  parameter int BANKS   = 4,
  parameter int ROW_W   = 13,
  parameter int COL_W   = 10,
  parameter int T_RCD   = 3,
  parameter int T_RP    = 3,
  parameter int T_RFC   = 8,
  parameter int REF_INT = 780,
  localparam int BA_W   = $clog2(BANKS),
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BA_W-1:0]   req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_ap,
  input  logic [1:0]        cfg_bl,
  input  logic [1:0]        cfg_cl,
  output logic [2:0]        cmd_o,
  output logic [BA_W-1:0]   cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_ap,
  output logic              rd_valid,
  output logic              rd_half,
  output logic              wr_valid
);

  localparam int AP_MAX  = T_RP + 3 + 4;
  localparam int TMR_MAX = (T_RFC > AP_MAX) ? ((T_RFC > T_RCD) ? T_RFC : T_RCD)
                                            : ((AP_MAX > T_RCD) ? AP_MAX : T_RCD);
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  seq_state_e        st_q, st_n;
  ddr_cmd_e          cmd_n;
  logic              q_write, q_ap;
  logic [BA_W-1:0]   q_bank;
  logic [ROW_W-1:0]  q_row;
  logic [COL_W-1:0]  q_col;

  logic [BANKS-1:0]  b_open, b_zero;
  logic [ROW_W-1:0]  b_row [BANKS];
  logic              sel_open, sel_zero, any_open, all_zero;
  logic [ROW_W-1:0]  sel_row;

  logic              col_ok, ref_pend, accept, col_fire;
  logic [1:0]        col_lat;
  logic [3:0]        clocks;
  logic [TMR_W-1:0]  ap_ld;

  assign sel_open = b_open[q_bank];
  assign sel_zero = b_zero[q_bank];
  assign sel_row  = b_row[q_bank];
  assign any_open = |b_open;
  assign all_zero = &b_zero;

  assign clocks   = burst_clocks(cfg_bl);
  assign col_lat  = q_write ? 2'd1 : cas_whole(cfg_cl);
  assign ap_ld    = TMR_W'(col_lat) + TMR_W'(clocks) + TMR_W'(T_RP - 1);
  assign col_fire = (cmd_n == CMD_RD) || (cmd_n == CMD_WR);

  assign req_ready = (st_q == S_IDLE) && !ref_pend;
  assign accept    = req_valid && req_ready;

  // one command decision per edge
  always_comb begin
    cmd_n = CMD_NOP;
    st_n  = st_q;
    unique case (st_q)
      S_IDLE: begin
        if (ref_pend) begin
          if (any_open) begin
            if (all_zero && col_ok) cmd_n = CMD_PREA;
          end else if (all_zero && col_ok) begin
            cmd_n = CMD_REF;
          end
        end else if (accept) begin
          st_n = S_WORK;
        end
      end
      S_WORK: begin
        if (!sel_open) begin
          if (sel_zero) cmd_n = CMD_ACT;
        end else if (sel_row != q_row) begin
          if (sel_zero && col_ok) cmd_n = CMD_PRE;
        end else if (sel_zero && col_ok) begin
          cmd_n = q_write ? CMD_WR : CMD_RD;
          st_n  = S_IDLE;
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= S_IDLE;
      q_write <= 1'b0;
      q_ap    <= 1'b0;
      q_bank  <= '0;
      q_row   <= '0;
      q_col   <= '0;
    end else begin
      st_q <= st_n;
      if (accept) begin
        q_write <= req_write;
        q_ap    <= req_ap;
        q_bank  <= req_bank;
        q_row   <= req_row;
        q_col   <= req_col;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_o    <= CMD_NOP;
      cmd_bank <= '0;
      cmd_addr <= '0;
      cmd_ap   <= 1'b0;
    end else begin
      cmd_o    <= cmd_n;
      cmd_bank <= q_bank;
      cmd_addr <= (cmd_n == CMD_ACT) ? ADDR_W'(q_row) : ADDR_W'(q_col);
      cmd_ap   <= col_fire && q_ap;
    end
  end

  for (genvar i = 0; i < BANKS; i++) begin : g_bank
    logic             hit, set_o, clr_o, ld_en;
    logic [TMR_W-1:0] ld_val;

    assign hit = (q_bank == BA_W'(i));

    always_comb begin
      set_o  = 1'b0;
      clr_o  = 1'b0;
      ld_en  = 1'b0;
      ld_val = '0;
      unique case (cmd_n)
        CMD_ACT: if (hit) begin
          set_o = 1'b1; ld_en = 1'b1; ld_val = TMR_W'(T_RCD - 1);
        end
        CMD_PRE: if (hit) begin
          clr_o = 1'b1; ld_en = 1'b1; ld_val = TMR_W'(T_RP - 1);
        end
        CMD_RD, CMD_WR: if (hit && q_ap) begin
          clr_o = 1'b1; ld_en = 1'b1; ld_val = ap_ld;
        end
        CMD_PREA: begin
          clr_o = 1'b1; ld_en = 1'b1; ld_val = TMR_W'(T_RP - 1);
        end
        CMD_REF: begin
          ld_en = 1'b1; ld_val = TMR_W'(T_RFC - 1);
        end
        default: ;
      endcase
    end

    ddr_bank_trk #(.ROW_W(ROW_W), .TMR_W(TMR_W)) u_trk (
      .clk      (clk),
      .rst      (rst),
      .set_open (set_o),
      .set_row  (q_row),
      .clr_open (clr_o),
      .ld_en    (ld_en),
      .ld_val   (ld_val),
      .is_open  (b_open[i]),
      .row_q    (b_row[i]),
      .tmr_zero (b_zero[i])
    );
  end

  ddr_data_win #(.AGE_W(4)) u_win (
    .clk      (clk),
    .rst      (rst),
    .fire     (col_fire),
    .fire_wr  (q_write),
    .lat_i    (col_lat),
    .clocks_i (clocks),
    .half_i   (cfg_cl == 2'd1),
    .col_ok   (col_ok),
    .rd_valid (rd_valid),
    .rd_half  (rd_half),
    .wr_valid (wr_valid)
  );

  ddr_ref_timer #(.REF_INT(REF_INT)) u_ref (
    .clk  (clk),
    .rst  (rst),
    .ack  (cmd_n == CMD_REF),
    .pend (ref_pend)
  );

endmodule

// File: rtl/ddr_cmd_seq_chk.sv
module ddr_cmd_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] cmd_o,
  input logic       rd_valid,
  input logic       rd_half,
  input logic       wr_valid
);

  // R11
  legal_code_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_o <= 3'd6);

  // R2
  act_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_o == 3'd1 |=> cmd_o == 3'd0);

  // R10
  ref_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_o == 3'd6 |=> cmd_o == 3'd0);

  // R9
  close_no_window_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 3'd4 || cmd_o == 3'd5 || cmd_o == 3'd6) |-> !(rd_valid || wr_valid));

  // R6
  window_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && wr_valid));

  // R7
  half_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    rd_half |-> rd_valid);

  // R8
  write_window_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_o == 3'd3 |=> wr_valid);

endmodule

bind ddr_cmd_seq ddr_cmd_seq_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .cmd_o    (cmd_o),
  .rd_valid (rd_valid),
  .rd_half  (rd_half),
  .wr_valid (wr_valid)
);

// File: tb/ddr_cmd_seq_tb.sv
module ddr_cmd_seq_tb;

  localparam int ROW_W = 13, COL_W = 10, ADDR_W = 13, REF_INT = 400;
  localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3, C_PRE = 4, C_PREA = 5, C_REF = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_ready, req_write = 0, req_ap = 0;
  logic [1:0] req_bank = 0, cfg_bl = 0, cfg_cl = 0;
  logic [ROW_W-1:0] req_row = 0;
  logic [COL_W-1:0] req_col = 0;
  logic [2:0] cmd_o;
  logic [1:0] cmd_bank;
  logic [ADDR_W-1:0] cmd_addr;
  logic cmd_ap, rd_valid, rd_half, wr_valid;

  ddr_cmd_seq #(.REF_INT(REF_INT)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_row(req_row),
    .req_col(req_col), .req_ap(req_ap), .cfg_bl(cfg_bl), .cfg_cl(cfg_cl),
    .cmd_o(cmd_o), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .cmd_ap(cmd_ap),
    .rd_valid(rd_valid), .rd_half(rd_half), .wr_valid(wr_valid));

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always @(posedge clk) if (rst) cyc <= 0; else cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int clocks_of(input logic [1:0] c);
    return (c == 0) ? 1 : (c == 1) ? 2 : 4;
  endfunction
  function automatic int lat_of(input logic [1:0] c);
    return (c <= 1) ? 2 : 3;
  endfunction

  // scoreboard
  bit sb_open[4];
  int sb_row[4], sb_act_ok[4], sb_col_ok[4];
  int col_free = 0, rs = 1, re = 0, ws = 1, we = 0;
  bit rhalf = 0;
  bit busy = 0, f_wr = 0, f_ap = 0;
  int f_bank = 0, f_row = 0, f_col = 0, n_sent = 0, n_served = 0;
  int n_act = 0, n_pre = 0, n_prea = 0, n_ref = 0, n_rdv = 0, n_wrv = 0, n_half = 0;
  int last_act = 0, last_pre = 0, last_col = 0, last_ref = -1, act_row = 0;
  int rd_rise = 0, wr_rise = 0, half_rise = 0;
  bit last_ap = 0, prev_rd = 0, prev_wr = 0, prev_half = 0;

  initial for (int b = 0; b < 4; b++) begin
    sb_open[b] = 0; sb_row[b] = 0; sb_act_ok[b] = 0; sb_col_ok[b] = 0;
  end

  always @(negedge clk) if (!rst && !done) begin
    chk(rd_valid == (cyc >= rs && cyc <= re), "R6 rd_valid", rd_valid, int'(cyc >= rs && cyc <= re));
    chk(rd_half == (rhalf && cyc >= rs && cyc <= re), "R7 rd_half", rd_half, int'(rhalf && cyc >= rs && cyc <= re));
    chk(wr_valid == (cyc >= ws && cyc <= we), "R8 wr_valid", wr_valid, int'(cyc >= ws && cyc <= we));
    chk(cmd_o <= 6, "R11 code", cmd_o, 6);
    if (rd_valid) n_rdv++;
    if (wr_valid) n_wrv++;
    if (rd_half) n_half++;
    if (rd_valid && !prev_rd) rd_rise = cyc;
    if (wr_valid && !prev_wr) wr_rise = cyc;
    if (rd_half && !prev_half) half_rise = cyc;
    prev_rd = rd_valid; prev_wr = wr_valid; prev_half = rd_half;
    case (int'(cmd_o))
      C_ACT: begin
        n_act++; last_act = cyc; act_row = int'(cmd_addr);
        chk(busy && cmd_bank == f_bank && int'(cmd_addr) == f_row, "R2 act target", int'(cmd_addr), f_row);
        chk(!sb_open[cmd_bank], "R4 act on open bank", 1, 0);
        chk(cyc >= sb_act_ok[cmd_bank], "R5 act too early", cyc, sb_act_ok[cmd_bank]);
        sb_open[cmd_bank] = 1; sb_row[cmd_bank] = int'(cmd_addr); sb_col_ok[cmd_bank] = cyc + 3;
      end
      C_RD, C_WR: begin
        int l, b;
        l = (cmd_o == C_WR) ? 1 : lat_of(cfg_cl);
        b = clocks_of(cfg_bl);
        last_col = cyc; last_ap = cmd_ap;
        chk(busy && cmd_bank == f_bank && int'(cmd_addr) == f_col && cmd_ap == f_ap
            && (cmd_o == C_WR) == f_wr, "R2 column target", int'(cmd_addr), f_col);
        chk(sb_open[cmd_bank] && sb_row[cmd_bank] == f_row, "R3 row open", sb_row[cmd_bank], f_row);
        chk(cyc >= sb_col_ok[cmd_bank], "R2 act-to-column", cyc, sb_col_ok[cmd_bank]);
        chk(cyc >= col_free, "R9 column spacing", cyc, col_free);
        if (cmd_o == C_RD) begin rs = cyc + l; re = cyc + l + b - 1; rhalf = (cfg_cl == 1); end
        else begin ws = cyc + 1; we = cyc + b; end
        col_free = cyc + l + b;
        if (cmd_ap) begin sb_open[cmd_bank] = 0; sb_act_ok[cmd_bank] = cyc + l + b + 3; end
        busy = 0; n_served++;
      end
      C_PRE: begin
        n_pre++; last_pre = cyc;
        chk(sb_open[cmd_bank] && sb_row[cmd_bank] != f_row, "R4 pre target", sb_row[cmd_bank], f_row);
        chk(cyc >= col_free && cyc >= sb_col_ok[cmd_bank], "R9 pre timing", cyc, col_free);
        sb_open[cmd_bank] = 0; sb_act_ok[cmd_bank] = cyc + 3;
      end
      C_PREA: begin
        n_prea++;
        chk(cyc >= col_free, "R10 prea after window", cyc, col_free);
        for (int b = 0; b < 4; b++) begin
          if (sb_open[b]) chk(cyc >= sb_col_ok[b], "R10 prea timing", cyc, sb_col_ok[b]);
          sb_open[b] = 0; sb_act_ok[b] = cyc + 3;
        end
      end
      C_REF: begin
        n_ref++;
        chk(cyc >= col_free, "R10 ref after window", cyc, col_free);
        for (int b = 0; b < 4; b++) begin
          chk(!sb_open[b] && cyc >= sb_act_ok[b], "R10 ref banks idle", cyc, sb_act_ok[b]);
          sb_act_ok[b] = cyc + 8;
        end
        chk(cyc - last_ref <= REF_INT + 40, "R10 ref interval", cyc - last_ref, REF_INT + 40);
        chk(!busy, "R10 ref during request", 1, 0);
        last_ref = cyc;
      end
      default: ;
    endcase
  end

  task automatic send(input bit wr, input int bank, input int row, input int col, input bit ap);
    int t = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_bank = 2'(bank);
    req_row = ROW_W'(row); req_col = COL_W'(col); req_ap = ap;
    while (!req_ready && t < 3000) begin @(negedge clk); t++; end
    @(posedge clk);
    busy = 1; f_wr = wr; f_ap = ap; f_bank = bank; f_row = row; f_col = col; n_sent++;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_idle(input int extra);
    int t = 0;
    while (busy && t < 3000) begin @(negedge clk); t++; end
    repeat (extra) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    int c1, k, p;
    void'($urandom(32'd5021));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cmd_o == C_NOP && !rd_valid && !wr_valid && !rd_half, "R1 reset outputs", cmd_o, 0);
    rst = 0;
    @(negedge clk);
    chk(req_ready == 1, "R1 ready after reset", req_ready, 1);

    // R2 closed bank, BL4 CAS2
    cfg_bl = 1; cfg_cl = 0;
    send(0, 0, 5, 8, 0); wait_idle(0);
    chk(last_col - last_act == 3, "R2 act-to-read gap", last_col - last_act, 3);
    chk(act_row == 5, "R2 act row", act_row, 5);
    k = n_rdv; repeat (6) @(negedge clk);
    chk(n_rdv - k == 2, "R6 read beats", n_rdv - k, 2);
    chk(rd_rise - last_col == 2, "R6 read latency", rd_rise - last_col, 2);

    // R3 hit, write
    k = n_act; p = n_wrv;
    send(1, 0, 5, 16, 0); wait_idle(5);
    chk(n_act == k, "R3 no activate on hit", n_act - k, 0);
    chk(n_wrv - p == 2, "R8 write beats", n_wrv - p, 2);
    chk(wr_rise - last_col == 1, "R8 write latency", wr_rise - last_col, 1);

    // R4 row conflict
    send(0, 0, 9, 4, 0); wait_idle(0);
    chk(last_act - last_pre == 3, "R4 pre-to-act", last_act - last_pre, 3);
    chk(last_col - last_act == 3, "R4 act-to-read", last_col - last_act, 3);

    // R5 auto-precharge, BL8 CAS3
    repeat (10) @(negedge clk);
    cfg_bl = 2; cfg_cl = 2;
    send(0, 1, 2, 0, 1); wait_idle(0);
    c1 = last_col;
    chk(last_ap == 1, "R5 ap flag", last_ap, 1);
    p = n_pre;
    send(0, 1, 2, 8, 0); wait_idle(0);
    chk(last_act - c1 == 10, "R5 ap to reopen", last_act - c1, 10);
    chk(n_pre == p, "R5 no explicit pre", n_pre - p, 0);

    // R9 back-to-back columns, BL8 CAS3
    send(0, 1, 2, 32, 0); wait_idle(0);
    c1 = last_col;
    send(0, 1, 2, 40, 0); wait_idle(0);
    chk(last_col - c1 == 7, "R9 column gap", last_col - c1, 7);

    // R7 CAS 2.5, BL2
    repeat (10) @(negedge clk);
    cfg_bl = 0; cfg_cl = 1;
    k = n_half;
    send(0, 2, 7, 3, 0); wait_idle(6);
    chk(n_half - k == 1, "R7 half cycles", n_half - k, 1);
    chk(half_rise - last_col == 2, "R7 half start", half_rise - last_col, 2);

    // R11 idle NOP
    for (int i = 0; i < 5; i++) begin
      chk(cmd_o == C_NOP, "R11 idle nop", cmd_o, C_NOP);
      @(negedge clk);
    end

    // random mix, back to back
    for (int i = 0; i < 400; i++) begin
      if (i % 40 == 0) begin
        wait_idle(12);
        cfg_bl = 2'($urandom_range(0, 3));
        cfg_cl = 2'($urandom_range(0, 3));
      end
      send(1'($urandom_range(0, 1)), $urandom_range(0, 3), $urandom_range(0, 2),
           $urandom_range(0, 1023), ($urandom_range(0, 3) == 0));
    end
    wait_idle(0);
    repeat (2 * REF_INT) @(negedge clk);

    chk(n_served == n_sent, "R2 all served", n_served, n_sent);
    chk(n_ref >= 2, "R10 refresh issued", n_ref, 2);
    chk(n_prea >= 1, "R10 precharge-all seen", n_prea, 1);
    chk(cyc - last_ref <= REF_INT + 40, "R10 final interval", cyc - last_ref, REF_INT + 40);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule